// File: doc/BRIEF.md
# Unlock-Keyed Flash Command Sequencer

This block sits on the device side of a byte-wide parallel flash bus and interprets host write cycles. Every command opens with a two-write key sequence at fixed addresses. After the key, a command byte selects one of four things: a byte program, a second key followed by an erase code, entry to the identification view, or exit from it. A byte program or an erase starts an internal operation. A cycle-count timer stands in for the real program and erase durations, and a behavioural byte array receives the result when the timer expires.

While an operation runs, reads do not return array contents. They return a polling byte. Bit 7 of that byte is a completion flag: it reads as the inverse of the programmed byte's bit 7, and it reads as 0 during an erase. Bit 6 flips on every read. Once the operation finishes, reads return true array data again. The erase granularity is a sector of `2**SECTOR_AW` bytes, a block of sixteen adjacent sectors, or the whole array.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `busy` is 0, the identification view is off and every array byte reads FFh.
- R2: A command is accepted only after the key: data AAh to address 555h, then data 55h to address 2AAh. The comparison uses address bits [10:0] only.
- R3: A byte program is the key, then A0h to 555h, then a write carrying the target address and data. The stored byte becomes the old byte ANDed with the data. `busy` is high for exactly PROG_CYCLES cycles, starting in the cycle after the last write.
- R4: While a program runs, a read returns bit 7 equal to the inverse of bit 7 of the programmed data. Bits 5..0 of that read are 0.
- R5: While an operation runs, bit 6 of the first read is 0 and successive reads alternate it. After completion, reads return stored data and repeated reads are equal.
- R6: A sector erase is the key, 80h to 555h, the key again, then 30h to any address in the sector. It sets only that sector (address bits above SECTOR_AW equal) to FFh.
- R7: A block erase is the same six-write sequence ending in 50h to any address in the block. It sets only the block (address bits above SECTOR_AW+3 equal) to FFh.
- R8: A chip erase is the same six-write sequence ending in 10h to 555h. It sets every byte to FFh. During any erase, bit 7 of a read is 0. Every erase keeps `busy` high for exactly ERASE_CYCLES cycles.
- R9: Writes made while `busy` is high are ignored. They neither change the array nor extend the busy time.
- R10: The key followed by 90h to 555h turns on the identification view. While it is on and no operation runs, address 0 reads MFR_CODE (9Dh), address 1 reads DEVICE_CODE, and every other address reads 00h.
- R11: The identification view turns off on the key followed by F0h to 555h, or on a single F0h write to any address.
- R12: A write that does not match the expected step returns the sequencer to idle. It changes no data and starts no operation.
- R13: A read (`rd_en` high in one cycle) updates `rdata` at that clock edge, and `rdata` holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write cycle strobe |
| rd_en | input | 1 | Bus read cycle strobe |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Registered read data, polling byte or identification code |
| busy | output | 1 | High while a program or erase operation runs |

## Verification
Programs are tried with data that has bit 7 clear and with data that has bit 7 set. This separates correct inversion of the polling flag from a constant value. Reprogramming the same byte shows that the store is an AND and not a replace. Sector, block and chip erases are each applied to a layout where bytes sit inside and just outside the addressed region, which exposes wrong boundary bits. Broken key sequences, writes during a chip erase and both exit forms of the identification view show that stray writes leave the array and the timer unchanged.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PROG = 3'd1,
    OP_SECT = 3'd2,
    OP_BLK  = 3'd3,
    OP_CHIP = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_KEY1  = 3'd1,
    SQ_KEY2  = 3'd2,
    SQ_PDATA = 3'd3,
    SQ_ERA1  = 3'd4,
    SQ_ERA2  = 3'd5,
    SQ_ERA3  = 3'd6
  } seq_e;

  localparam int          CMP_W    = 11;
  localparam logic [10:0] KEY_ADR1 = 11'h555;
  localparam logic [10:0] KEY_ADR2 = 11'h2AA;
  localparam logic [7:0]  KEY_DAT1 = 8'hAA;
  localparam logic [7:0]  KEY_DAT2 = 8'h55;
  localparam logic [7:0]  CMD_PROG = 8'hA0;
  localparam logic [7:0]  CMD_ERAS = 8'h80;
  localparam logic [7:0]  CMD_IDON = 8'h90;
  localparam logic [7:0]  CMD_IDOF = 8'hF0;
  localparam logic [7:0]  FIN_CHIP = 8'h10;
  localparam logic [7:0]  FIN_SECT = 8'h30;
  localparam logic [7:0]  FIN_BLK  = 8'h50;

  // polling byte: completion flag in bit 7, toggle in bit 6, rest zero
  function automatic logic [7:0] poll_byte(op_e kind, logic data7, logic tog);
    logic flag;
    flag = (kind == OP_PROG) ? ~data7 : 1'b0;
    return {flag, tog, 6'b0};
  endfunction

  function automatic logic key_hit(logic [10:0] a, logic [7:0] d,
                                   logic [10:0] ka, logic [7:0] kd);
    return (a == ka) && (d == kd);
  endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          accept,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          launch,
  output op_e           launch_op,
  output op_e           op_q,
  output logic [AW-1:0] tgt_q,
  output logic [7:0]    data_q,
  output logic          id_on
);

  seq_e        st, nxt;
  logic        wr_ok, id_set, id_clr;
  logic [10:0] lo;
  logic        k1, k2, at_key1;

  assign wr_ok   = wr_en && accept;
  assign lo      = addr[CMP_W-1:0];
  assign k1      = key_hit(lo, wdata, KEY_ADR1, KEY_DAT1);
  assign k2      = key_hit(lo, wdata, KEY_ADR2, KEY_DAT2);
  assign at_key1 = (lo == KEY_ADR1);

  always_comb begin
    nxt       = SQ_IDLE;
    launch_op = OP_NONE;
    id_set    = 1'b0;
    id_clr    = 1'b0;
    case (st)
      SQ_IDLE: if (k1) nxt = SQ_KEY1;
      SQ_KEY1: if (k2) nxt = SQ_KEY2;
      SQ_KEY2: begin
        if (at_key1) begin
          case (wdata)
            CMD_PROG: nxt = SQ_PDATA;
            CMD_ERAS: nxt = SQ_ERA1;
            CMD_IDON: id_set = 1'b1;
            default:  nxt = SQ_IDLE;
          endcase
        end
      end
      SQ_PDATA: launch_op = OP_PROG;
      SQ_ERA1:  if (k1) nxt = SQ_ERA2;
      SQ_ERA2:  if (k2) nxt = SQ_ERA3;
      SQ_ERA3: begin
        if (wdata == FIN_CHIP && at_key1) launch_op = OP_CHIP;
        else if (wdata == FIN_SECT)       launch_op = OP_SECT;
        else if (wdata == FIN_BLK)        launch_op = OP_BLK;
      end
      default: nxt = SQ_IDLE;
    endcase
    if (st != SQ_PDATA && wdata == CMD_IDOF) id_clr = 1'b1;
  end

  assign launch = wr_ok && (launch_op != OP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      id_on  <= 1'b0;
      op_q   <= OP_NONE;
      tgt_q  <= '0;
      data_q <= '0;
    end else if (wr_ok) begin
      st <= nxt;
      if (id_set)      id_on <= 1'b1;
      else if (id_clr) id_on <= 1'b0;
      if (launch_op != OP_NONE) begin
        op_q   <= launch_op;
        tgt_q  <= addr;
        data_q <= wdata;
      end
    end
  end

endmodule

// File: rtl/fcd_busy_timer.sv
module fcd_busy_timer
  import fcd_pkg::*;
#(
  parameter int PROG_CYCLES  = 12,
  parameter int ERASE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  op_e  launch_op,
  output logic busy,
  output logic done
);

  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (launch) begin
      cnt <= (launch_op == OP_PROG) ? CW'(PROG_CYCLES) : CW'(ERASE_CYCLES);
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end
  end

endmodule

// File: rtl/fcd_array.sv
module fcd_array
  import fcd_pkg::*;
#(
  parameter int AW        = 11,
  parameter int SECTOR_AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  op_e           op,
  input  logic [AW-1:0] tgt,
  input  logic [7:0]    din,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte
);

  localparam int DEPTH   = 1 << AW;
  localparam int BLK_LSB = SECTOR_AW + 4;

  logic [7:0] mem [DEPTH];

  function automatic logic wipe_hit(op_e k, logic [AW-1:0] a, logic [AW-1:0] t);
    case (k)
      OP_SECT: return a[AW-1:SECTOR_AW] == t[AW-1:SECTOR_AW];
      OP_BLK:  return a[AW-1:BLK_LSB] == t[AW-1:BLK_LSB];
      OP_CHIP: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wipe_hit(op, AW'(i), tgt))
          mem[i] <= 8'hFF;
        else if (op == OP_PROG && AW'(i) == tgt)
          mem[i] <= mem[i] & din;
      end
    end
  end

  assign rd_byte = mem[rd_addr];

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import fcd_pkg::*;
#(
  parameter int         AW          = 11,
  parameter logic [7:0] MFR_CODE    = 8'h9D,
  parameter logic [7:0] DEVICE_CODE = 8'h3E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          busy,
  input  logic          launch,
  input  logic          id_on,
  input  op_e           op,
  input  logic [7:0]    op_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [7:0]    array_byte,
  output logic          tog,
  output logic [7:0]    rdata
);

  function automatic logic [7:0] id_byte(logic [AW-1:0] a);
    if (a == AW'(0)) return MFR_CODE;
    if (a == AW'(1)) return DEVICE_CODE;
    return 8'h00;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog   <= 1'b0;
      rdata <= 8'h00;
    end else begin
      if (launch) tog <= 1'b0;
      else if (rd_en && busy) tog <= ~tog;
      if (rd_en) begin
        if (busy)       rdata <= poll_byte(op, op_data[7], tog);
        else if (id_on) rdata <= id_byte(rd_addr);
        else            rdata <= array_byte;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         AW           = 11,
  parameter int         SECTOR_AW    = 6,
  parameter int         PROG_CYCLES  = 12,
  parameter int         ERASE_CYCLES = 40,
  parameter logic [7:0] MFR_CODE     = 8'h9D,
  parameter logic [7:0] DEVICE_CODE  = 8'h3E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          busy
);

  logic          launch_w, commit_w, id_mode_w, tog_w;
  op_e           launch_op_w, op_w;
  logic [AW-1:0] op_addr_w;
  logic [7:0]    op_data_w, array_byte_w;

  fcd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .accept(!busy),
    .addr(addr), .wdata(wdata), .launch(launch_w), .launch_op(launch_op_w),
    .op_q(op_w), .tgt_q(op_addr_w), .data_q(op_data_w), .id_on(id_mode_w)
  );

  fcd_busy_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch_w), .launch_op(launch_op_w),
    .busy(busy), .done(commit_w)
  );

  fcd_array #(.AW(AW), .SECTOR_AW(SECTOR_AW)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit_w), .op(op_w), .tgt(op_addr_w),
    .din(op_data_w), .rd_addr(addr), .rd_byte(array_byte_w)
  );

  fcd_read_mux #(.AW(AW), .MFR_CODE(MFR_CODE), .DEVICE_CODE(DEVICE_CODE)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy), .launch(launch_w),
    .id_on(id_mode_w), .op(op_w), .op_data(op_data_w), .rd_addr(addr),
    .array_byte(array_byte_w), .tog(tog_w), .rdata(rdata)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int         AW           = 11,
  parameter int         PROG_CYCLES  = 12,
  parameter int         ERASE_CYCLES = 40,
  parameter logic [7:0] MFR_CODE     = 8'h9D
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          busy,
  input logic          launch,
  input op_e           op,
  input logic [7:0]    op_data,
  input logic          id_mode,
  input logic          tog,
  input logic [AW-1:0] addr,
  input logic [7:0]    rdata
);

  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;

  int run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else if (busy) run <= run + 1;
    else run <= 0;
  end

  // R9
  busy_blocks_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch);

  // R3
  launch_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R8
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run <= MAXC);

  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (tog != $past(tog)));

  // R4
  prog_poll_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && op == OP_PROG) |=> (rdata[7] == ~op_data[7]) && (rdata[5:0] == 6'd0));

  // R8
  erase_poll_bit7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && op != OP_PROG) |=> !rdata[7]);

  // R10
  id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy && id_mode && addr == AW'(0)) |=> (rdata == MFR_CODE));

endmodule

bind flash_cmd_decoder fcd_checker #(
  .AW(AW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES), .MFR_CODE(MFR_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy), .launch(launch_w),
  .op(op_w), .op_data(op_data_w), .id_mode(id_mode_w), .tog(tog_w),
  .addr(addr), .rdata(rdata)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  localparam int AW    = 11;
  localparam int PROGC = 12;
  localparam int ERAC  = 40;
  localparam logic [7:0] DEVC = 8'h3E;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          busy;

  int checks = 0;
  int errors = 0;
  int run = 0;
  int last_run = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .PROG_CYCLES(PROGC), .ERASE_CYCLES(ERAC),
                      .DEVICE_CODE(DEVC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

  // length of each busy stretch in clock cycles
  always @(posedge clk) begin
    if (busy) run = run + 1;
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] q);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; q = rdata;
  endtask

  task automatic key();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  task automatic erase_seq(logic [AW-1:0] a, logic [7:0] code);
    key(); wr(11'h555, 8'h80); key(); wr(a, code);
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 500) begin @(negedge clk); n++; end
    chk(req, {31'd0, busy}, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", {31'd0, busy}, 0);
    chk("R1 rdata after reset", rdata, 8'h00);
    rd(11'h005, v); chk("R1 array erased", v, 8'hFF);
    rd(11'h000, v); chk("R1 id view off", v, 8'hFF);
    @(negedge clk); chk("R13 rdata holds", rdata, 8'hFF);
  endtask

  task automatic t_program();
    key(); wr(11'h555, 8'hA0); wr(11'h123, 8'h5A);
    chk("R3 busy after program", {31'd0, busy}, 1);
    rd(11'h123, v); chk("R4 poll bit7 inverted (data7=0)", v, 8'h80);
    rd(11'h123, v); chk("R5 toggle second read", v, 8'hC0);
    rd(11'h123, v); chk("R5 toggle third read", v, 8'h80);
    wait_idle("R3 program finishes");
    chk("R3 program busy length", last_run, PROGC);
    rd(11'h123, v); chk("R3 programmed byte", v, 8'h5A);
    rd(11'h123, v); chk("R5 toggle stopped", v, 8'h5A);
  endtask

  task automatic t_and();
    key(); wr(11'h555, 8'hA0); wr(11'h123, 8'hF0);
    rd(11'h123, v); chk("R4 poll bit7 inverted (data7=1)", v, 8'h00);
    rd(11'h123, v); chk("R5 toggle on program", v, 8'h40);
    wait_idle("R3 reprogram finishes");
    rd(11'h123, v); chk("R3 AND of old and new", v, 8'h50);
  endtask

  task automatic t_break();
    key(); wr(11'h555, 8'h12); wr(11'h555, 8'hA0); wr(11'h124, 8'h00);
    chk("R12 no launch after bad command", {31'd0, busy}, 0);
    wr(11'h554, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h124, 8'h00);
    chk("R2 wrong key address", {31'd0, busy}, 0);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h56); wr(11'h555, 8'hA0); wr(11'h124, 8'h00);
    chk("R2 wrong key data", {31'd0, busy}, 0);
    key(); wr(11'h555, 8'h80); key(); wr(11'h555, 8'h20);
    chk("R12 bad erase code", {31'd0, busy}, 0);
    rd(11'h124, v); chk("R12 byte untouched", v, 8'hFF);
    rd(11'h123, v); chk("R12 other byte untouched", v, 8'h50);
  endtask

  task automatic t_sector();
    key(); wr(11'h555, 8'hA0); wr(11'h040, 8'h11); wait_idle("R3 p1");
    key(); wr(11'h555, 8'hA0); wr(11'h07F, 8'h33); wait_idle("R3 p2");
    key(); wr(11'h555, 8'hA0); wr(11'h080, 8'h22); wait_idle("R3 p3");
    erase_seq(11'h05C, 8'h30);
    rd(11'h040, v); chk("R8 erase poll first read", v, 8'h00);
    rd(11'h040, v); chk("R5 erase toggle", v, 8'h40);
    wait_idle("R6 sector erase finishes");
    chk("R8 sector erase busy length", last_run, ERAC);
    rd(11'h040, v); chk("R6 sector low end erased", v, 8'hFF);
    rd(11'h07F, v); chk("R6 sector high end erased", v, 8'hFF);
    rd(11'h080, v); chk("R6 next sector kept", v, 8'h22);
    rd(11'h123, v); chk("R6 far byte kept", v, 8'h50);
  endtask

  task automatic t_block();
    key(); wr(11'h555, 8'hA0); wr(11'h400, 8'h77); wait_idle("R3 p4");
    erase_seq(11'h7FF, 8'h50);
    wait_idle("R7 block erase finishes");
    rd(11'h400, v); chk("R7 block erased", v, 8'hFF);
    rd(11'h3FF, v); chk("R7 lower block kept", v, 8'hFF);
    rd(11'h080, v); chk("R7 lower block data kept", v, 8'h22);
  endtask

  task automatic t_chip();
    erase_seq(11'h555, 8'h10);
    rd(11'h000, v); chk("R8 chip erase poll", v, 8'h00);
    key(); wr(11'h555, 8'hA0); wr(11'h200, 8'h00);
    wait_idle("R8 chip erase finishes");
    chk("R9 busy not extended", last_run, ERAC);
    rd(11'h080, v); chk("R8 chip erased", v, 8'hFF);
    rd(11'h123, v); chk("R8 chip erased far", v, 8'hFF);
    rd(11'h200, v); chk("R9 write during erase ignored", v, 8'hFF);
  endtask

  task automatic t_id();
    key(); wr(11'h555, 8'h90);
    rd(11'h000, v); chk("R10 manufacturer code", v, 8'h9D);
    rd(11'h001, v); chk("R10 device code", v, DEVC);
    rd(11'h002, v); chk("R10 other address", v, 8'h00);
    wr(11'h333, 8'hF0);
    rd(11'h000, v); chk("R11 single-write exit", v, 8'hFF);
    key(); wr(11'h555, 8'h90);
    rd(11'h001, v); chk("R10 re-entry", v, DEVC);
    key(); wr(11'h555, 8'hF0);
    rd(11'h001, v); chk("R11 keyed exit", v, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_and();
    t_break();
    t_sector();
    t_block();
    t_chip();
    t_id();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule